// File: doc/BRIEF.md
# SPI Pause (Hold) Controller

This block sits between the pins of a serial flash-style SPI slave and its command front-end. It lets the bus master pause a transfer by driving an active-low hold pin, without deselecting the slave. The block synchronises chip select, serial clock, hold and serial data to the system clock, keeps a single hold flag, and passes the front-end qualified serial-clock edge strobes, the synchronised data bit and a masked output enable for the serial data output.

While the pause is in force, no clock edge strobes reach the front-end. Its bit and byte counters therefore stand still and carry on from the same bit after release. The output driver enable is forced off (high impedance). A pause only starts or ends while the serial clock is low. If the hold pin moves while the clock is high, the change takes effect when the clock next goes low. If chip select is released during a pause, the block asks the front-end for a reset of its serial state. The block then ignores the bus until chip select falls again with the hold pin high. Self-timed program, erase or status-write cycles are not touched by any of this: the block has no path to them, and the only thing it can send the front-end is the reset request.

Top module: `spi_hold_ctrl`

## Requirements
- R1: The hold flag (`held_o`) is 0 in any cycle that follows a cycle in which the synchronised chip select was high (1 = deselected). It is 0 after reset.
- R2: With the slave selected, the flag becomes 1 one cycle after the synchronised hold pin is seen at 0 together with a synchronised serial clock at 0. If the hold pin falls while the clock is 1, the flag stays 0 until the clock is seen at 0.
- R3: The flag returns to 0 one cycle after the synchronised hold pin is seen at 1 together with a synchronised clock at 0. If the clock is 1 at that moment, the flag stays 1 until the clock is seen at 0.
- R4: `sclk_rise_o` and `sclk_fall_o` are 0 in every cycle in which `held_o` is 1. This includes the clock edge that coincides with the end of a pause.
- R5: `so_oe_o` is 0 while held, deselected or locked out. Otherwise it equals `fe_so_oe_i`. `so_d_o` always equals `fe_so_d_i`.
- R6: `fe_rst_o` pulses for exactly one cycle when synchronised chip select rises while `held_o` is 1. It is never 1 at any other time.
- R7: After such a reset, `sel_o`, the edge strobes and `so_oe_o` stay 0 until a synchronised chip-select falling edge is seen with the hold pin at 1. A falling edge seen with the hold pin at 0 leaves the lockout in place.
- R8: Outside a pause and lockout, each serial clock rise (fall) while selected gives exactly one `sclk_rise_o` (`sclk_fall_o`) pulse. The count of pulses across a transfer split by a pause equals the number of clock rises made outside it.
- R9: Each pin reaches the block's logic through `SYNC_STAGES` flip-flops. `si_o` is the serial data pin delayed by `SYNC_STAGES` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n_i | input | 1 | Chip select pin, active low |
| sclk_i | input | 1 | Serial clock pin |
| hold_n_i | input | 1 | Pause pin, active low |
| si_i | input | 1 | Serial data input pin |
| fe_so_oe_i | input | 1 | Output-enable request from the front-end |
| fe_so_d_i | input | 1 | Output data bit from the front-end |
| sel_o | output | 1 | Slave selected and not locked out |
| sclk_rise_o | output | 1 | Qualified serial clock rising-edge strobe |
| sclk_fall_o | output | 1 | Qualified serial clock falling-edge strobe |
| si_o | output | 1 | Synchronised serial data bit |
| so_oe_o | output | 1 | Masked output-enable for the serial data output driver |
| so_d_o | output | 1 | Output data bit toward the pin |
| fe_rst_o | output | 1 | One-cycle reset request to the front-end |
| held_o | output | 1 | Pause in force |

## Verification
The bench attacks the deferred cases: the hold pin falling or rising while the clock is high. A design that acted on the pin edge itself would pause or resume half a bit early and let a stray strobe through. It also toggles clock and data during a pause and counts strobes across the whole transfer. A design that leaked an edge, or cleared the count instead of freezing it, shows a wrong total. Finally, it releases chip select mid-pause, then reselects first with the hold pin low and later with it high. A missing lockout, or one that clears too eagerly, shows up as strobes or an output enable where none may appear.

// File: rtl/hold_pkg.sv
package hold_pkg;

  // Pin bundle sampled into the system clock domain.
  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic hold_n;
    logic si;
  } pin_vec_t;

  localparam int PIN_W = $bits(pin_vec_t);

  // Idle bus: deselected, clock low, no pause, data low.
  localparam pin_vec_t PIN_IDLE = '{cs_n: 1'b1, sclk: 1'b0, hold_n: 1'b1, si: 1'b0};

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int              STAGES  = 2,
  parameter int              W       = 4,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= RST_VAL;
        else        stg_q <= din;
      end
      assign dout = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= {stg_q[STAGES-2:0], din};
      end
      assign dout = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/hold_state.sv
module hold_state (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic hold_n,
  input  logic prev_cs_n,
  output logic held,
  output logic lock
);

  logic held_q, held_d;
  logic lock_q, lock_d;
  logic cs_rise, cs_fall;

  assign cs_rise = cs_n & ~prev_cs_n;
  assign cs_fall = ~cs_n & prev_cs_n;

  // Next state: the flag may only move while the clock is low.
  always_comb begin
    held_d = held_q;
    if (cs_n || lock_q)  held_d = 1'b0;
    else if (!sclk)      held_d = ~hold_n;

    lock_d = lock_q;
    if (cs_rise && held_q)      lock_d = 1'b1;
    else if (cs_fall && hold_n) lock_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      held_q <= held_d;
      lock_q <= lock_d;
    end
  end

  assign held = held_q;
  assign lock = lock_q;

  AST_LOCK_CLEARS_WITH_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lock_q)) |-> ($past(hold_n) && !$past(cs_n))) else $error("lock released wrongly"); // R7

endmodule

// File: rtl/hold_gate.sv
module hold_gate (
  input  logic cs_n,
  input  logic sclk,
  input  logic si,
  input  logic prev_cs_n,
  input  logic prev_sclk,
  input  logic held,
  input  logic lock,
  input  logic fe_oe,
  input  logic fe_d,
  output logic sel,
  output logic rise,
  output logic fall,
  output logic si_out,
  output logic so_oe,
  output logic so_d,
  output logic fe_rst
);

  logic active;

  assign sel    = ~cs_n & ~lock;
  assign active = sel & ~held;
  assign rise   = active & sclk & ~prev_sclk;
  assign fall   = active & ~sclk & prev_sclk;
  assign so_oe  = active & fe_oe;
  assign so_d   = fe_d;
  assign si_out = si;
  assign fe_rst = cs_n & ~prev_cs_n & held;

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic hold_n_i,
  input  logic si_i,
  input  logic fe_so_oe_i,
  input  logic fe_so_d_i,
  output logic sel_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic si_o,
  output logic so_oe_o,
  output logic so_d_o,
  output logic fe_rst_o,
  output logic held_o
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_ff;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sn = rst_ff[1];

  // Pin synchronisation.
  pin_vec_t         raw_pins, cur;
  logic [PIN_W-1:0] sync_out;

  assign raw_pins = '{cs_n: cs_n_i, sclk: sclk_i, hold_n: hold_n_i, si: si_i};

  hold_sync #(
    .STAGES  (SYNC_STAGES),
    .W       (PIN_W),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .din   (raw_pins),
    .dout  (sync_out)
  );

  assign cur = pin_vec_t'(sync_out);

  // One-cycle history for edge detection.
  logic prev_cs_n, prev_sclk;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      prev_cs_n <= PIN_IDLE.cs_n;
      prev_sclk <= PIN_IDLE.sclk;
    end else begin
      prev_cs_n <= cur.cs_n;
      prev_sclk <= cur.sclk;
    end
  end

  logic held, lock;

  hold_state u_state (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cs_n      (cur.cs_n),
    .sclk      (cur.sclk),
    .hold_n    (cur.hold_n),
    .prev_cs_n (prev_cs_n),
    .held      (held),
    .lock      (lock)
  );

  hold_gate u_gate (
    .cs_n      (cur.cs_n),
    .sclk      (cur.sclk),
    .si        (cur.si),
    .prev_cs_n (prev_cs_n),
    .prev_sclk (prev_sclk),
    .held      (held),
    .lock      (lock),
    .fe_oe     (fe_so_oe_i),
    .fe_d      (fe_so_d_i),
    .sel       (sel_o),
    .rise      (sclk_rise_o),
    .fall      (sclk_fall_o),
    .si_out    (si_o),
    .so_oe     (so_oe_o),
    .so_d      (so_d_o),
    .fe_rst    (fe_rst_o)
  );

  assign held_o = held;

  AST_NO_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(cur.cs_n) |-> !held) else $error("held while deselected"); // R1

  AST_ENTER_ON_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cur.cs_n && !lock && !cur.sclk && !cur.hold_n) |=> held) else $error("pause not entered"); // R2

  AST_EXIT_ON_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_sn)
    (held && !cur.sclk && cur.hold_n) |=> !held) else $error("pause not left"); // R3

  AST_FLAG_MOVES_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_sn)
    (held != $past(held)) |-> ($past(cur.cs_n) || !$past(cur.sclk) || $past(lock))) else $error("flag moved with clock high"); // R2

  AST_NO_STROBE_HELD: assert property (@(posedge clk) disable iff (!rst_sn)
    held |-> (!sclk_rise_o && !sclk_fall_o)) else $error("strobe during pause"); // R4

  AST_SO_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_sn)
    held |-> !so_oe_o) else $error("output enabled during pause"); // R5

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sn)
    fe_rst_o |=> !fe_rst_o) else $error("reset request too long"); // R6

  AST_LOCK_SILENT: assert property (@(posedge clk) disable iff (!rst_sn)
    lock |-> (!sel_o && !sclk_rise_o && !sclk_fall_o && !so_oe_o)) else $error("activity in lockout"); // R7

endmodule

// File: tb/tb_spi_hold_ctrl.sv
module tb_spi_hold_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NS         = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, hold_n = 1'b1, si = 1'b0;
  logic fe_oe = 1'b0, fe_d = 1'b0;

  logic sel_o, rise_o, fall_o, si_o, so_oe_o, so_d_o, fe_rst_o, held_o;

  int checks = 0;
  int failures = 0;
  int rise_cnt = 0;
  int rst_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_hold_ctrl #(.SYNC_STAGES(NS)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .hold_n_i(hold_n), .si_i(si),
    .fe_so_oe_i(fe_oe), .fe_so_d_i(fe_d), .sel_o(sel_o), .sclk_rise_o(rise_o),
    .sclk_fall_o(fall_o), .si_o(si_o), .so_oe_o(so_oe_o), .so_d_o(so_d_o),
    .fe_rst_o(fe_rst_o), .held_o(held_o)
  );

  // Behavioural reference: bits {cs_n, sclk, hold_n, si}, oldest sample at index 0.
  logic [3:0] pipe[$];
  logic m_pcs = 1'b1, m_psclk = 1'b0, m_held = 1'b0, m_lock = 1'b0;

  initial for (int i = 0; i < NS; i++) pipe.push_back(4'b1010);

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [3:0] s;
    logic ncs, nsclk, nhold;
    s = pipe[0];
    ncs = s[3]; nsclk = s[2]; nhold = s[1];
    begin
      logic h, l;
      h = m_held; l = m_lock;
      if (ncs == 1'b1 || m_lock == 1'b1) h = 1'b0;
      else if (nsclk == 1'b0) h = !nhold;
      if (ncs && !m_pcs && m_held) l = 1'b1;
      else if (!ncs && m_pcs && nhold) l = 1'b0;
      if (!rst_n) begin h = 1'b0; l = 1'b0; end
      m_held = h; m_lock = l;
    end
    m_pcs = rst_n ? ncs : 1'b1;
    m_psclk = rst_n ? nsclk : 1'b0;
    pipe.push_back(rst_n ? {cs_n, sclk, hold_n, si} : 4'b1010);
    void'(pipe.pop_front());
  endtask

  task automatic compare();
    logic [3:0] s;
    logic e_sel, e_act;
    s = pipe[0];
    e_sel = !s[3] && !m_lock;
    e_act = e_sel && !m_held;
    check("R1 R2 R3 held", held_o, m_held);
    check("R7 sel", sel_o, e_sel);
    check("R4 R8 rise", rise_o, e_act && s[2] && !m_psclk);
    check("R4 R8 fall", fall_o, e_act && !s[2] && m_psclk);
    check("R5 so_oe", so_oe_o, e_act && fe_oe);
    check("R5 so_d", so_d_o, fe_d);
    check("R6 fe_rst", fe_rst_o, s[3] && !m_pcs && m_held);
    check("R9 si", si_o, s[0]);
    if (rise_o) rise_cnt++;
    if (fe_rst_o) rst_cnt++;
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      model_edge();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic sbit(input logic d);
    si = d; sclk = 1'b1; cyc(3);
    sclk = 1'b0; cyc(3);
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    check("R1 reset held", held_o, 1'b0);
    check("R6 reset fe_rst", fe_rst_o, 1'b0);
    check("R5 reset so_oe", so_oe_o, 1'b0);

    // R1: pause pin low while deselected does nothing.
    hold_n = 1'b0; cyc(6);
    check("R1 deselected no pause", held_o, 1'b0);
    hold_n = 1'b1; cyc(2);

    // Transfer of 8 bits split by a standard pause.
    fe_oe = 1'b1; fe_d = 1'b1;
    cs_n = 1'b0; cyc(4);
    rise_cnt = 0;
    sbit(1); sbit(0); sbit(1);
    hold_n = 1'b0; cyc(NS + 2);
    check("R2 pause entered", held_o, 1'b1);
    check("R5 so_oe off in pause", so_oe_o, 1'b0);
    for (int k = 0; k < 4; k++) sbit(k[0]);
    check("R4 no strobes in pause", rise_cnt == 3, 1'b1);
    hold_n = 1'b1; cyc(NS + 2);
    check("R3 pause ended", held_o, 1'b0);
    sbit(0); sbit(1); sbit(1); sbit(0); sbit(1);
    check("R8 rises across pause", rise_cnt == 8, 1'b1);

    // Deferred entry and exit.
    sclk = 1'b1; cyc(3);
    hold_n = 1'b0; cyc(6);
    check("R2 deferred while clock high", held_o, 1'b0);
    sclk = 1'b0; cyc(NS + 2);
    check("R2 entered at clock low", held_o, 1'b1);
    sclk = 1'b1; cyc(3);
    hold_n = 1'b1; cyc(6);
    check("R3 deferred while clock high", held_o, 1'b1);
    sclk = 1'b0; cyc(NS + 2);
    check("R3 left at clock low", held_o, 1'b0);

    // Deselect during pause: reset request and lockout.
    hold_n = 1'b0; cyc(NS + 2);
    rst_cnt = 0;
    cs_n = 1'b1; cyc(6);
    check("R6 single reset request", rst_cnt == 1, 1'b1);
    cs_n = 1'b0; cyc(4);
    hold_n = 1'b1; cyc(3);
    rise_cnt = 0;
    sbit(1); sbit(0);
    check("R7 locked after reselect with pause low", rise_cnt == 0, 1'b1);
    check("R7 so_oe off when locked", so_oe_o, 1'b0);
    cs_n = 1'b1; cyc(4);
    check("R6 no request outside pause", rst_cnt == 1, 1'b1);
    cs_n = 1'b0; cyc(4);
    sbit(1); sbit(1);
    check("R7 unlocked by clean reselect", rise_cnt == 2, 1'b1);
    check("R5 so_oe follows request", so_oe_o, 1'b1);
    fe_oe = 1'b0; cyc(1);
    check("R5 so_oe follows request low", so_oe_o, 1'b0);
    cs_n = 1'b1; cyc(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule